// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block decides when a small processor core may go to sleep, when it must be woken, and when the core may actually enter an interrupt handler. The core raises one of three sleep requests: wait for an interrupt, wait for an event, or sleep when the current handler returns. The block compares each interrupt's pending, enable and priority inputs against the core's current execution priority. It drives a sleeping status, a one-cycle wake pulse, and a handler-entry grant that carries the number of the winning interrupt.

Waking the core and granting handler entry are two separate decisions. When the hold mask is set, an interrupt that would otherwise qualify still wakes the core, but the grant stays low until the mask is cleared. The pending input is not touched, so the interrupt stays pending during the wait. In the wait-for-event mode, a one-bit event flag also wakes the core. An external event input sets it. A new rising edge on any pending bit sets it too, when the new-pending-event control is on, even if that interrupt is disabled or has too low a priority.

The state machine has six states.

| State | Meaning |
|---|---|
| ST_RUN | The core is awake. |
| ST_WFI | Sleep entered by a wait-for-interrupt request. |
| ST_SOE | Sleep entered by a sleep-on-exit request. |
| ST_WFE | Sleep entered by a wait-for-event request. |
| ST_WAKE | One-cycle wake pulse. |
| ST_DEFER | The core is awake, but handler entry is held off. |

The transitions are as follows.

- **sleep-interrupt:** ST_RUN goes to ST_WFI.
- **sleep-exit:** ST_RUN goes to ST_SOE.
- **sleep-event:** ST_RUN goes to ST_WFE, when the event flag is clear.
- **event-consume:** ST_RUN stays in ST_RUN and clears the event flag, when a wait-for-event request arrives while the flag is set.
- **wake-irq:** ST_WFI or ST_SOE goes to ST_WAKE.
- **wake-any:** ST_WFE goes to ST_WAKE on a qualifying interrupt or an event, and consumes the event flag.
- **resume:** ST_WAKE goes to ST_RUN.
- **defer:** ST_WAKE goes to ST_DEFER, when a qualifying interrupt is present and the hold mask is set.
- **release:** ST_DEFER goes to ST_RUN, when the hold mask clears or nothing qualifies any more.

If requests arrive together in ST_RUN, wait-for-interrupt wins over sleep-on-exit, and sleep-on-exit wins over wait-for-event. Sleep requests are ignored in every other state.

Top module: `slpw_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `sleeping`, `wake_pulse` and `entry_ok` are 0 and the event flag is clear. A wait-for-event request right after reset therefore enters sleep.
- R2: In the awake state, a request of any of the three sleep kinds sets `sleeping` from the next cycle on. The core stays asleep while no wake condition holds.
- R3: An interrupt qualifies only if it is pending and enabled and its 3-bit priority value is strictly less than `exec_prio`. A lower value means more urgent, and the value 8 means thread level. A disabled interrupt does not qualify, and neither does one whose value equals `exec_prio`.
- R4: A wake condition seen while asleep gives `wake_pulse`=1 for exactly one cycle, starting the cycle after the condition. `sleeping` is still 1 in that cycle and drops to 0 in the next cycle.
- R5: With `hold_mask`=1 and `boost_mask`=0, a qualifying interrupt wakes the core, but `entry_ok` stays 0. `entry_ok` rises in the same cycle that `hold_mask` is cleared while the interrupt is still pending.
- R6: With `boost_mask`=1 no interrupt qualifies, for either wake-up or handler entry.
- R7: Sleep entered with `exit_sleep_req` follows the same wake rule as wait-for-interrupt sleep.
- R8: Wait-for-event sleep wakes on a qualifying interrupt.
- R9: In wait-for-event sleep with `evt_on_new`=1, a new 0-to-1 edge on any pending bit wakes the core, even for a disabled interrupt. The same edge with `evt_on_new`=0 leaves the core asleep.
- R10: A pending bit that was already high before sleep began generates no event.
- R11: The external event input sets the one-bit event flag. A wait-for-event request while the flag is set clears the flag and does not enter sleep. Waking from wait-for-event sleep also clears the flag.
- R12: `entry_ok` is 1 when the core is awake, a qualifying interrupt exists and `hold_mask`=0. `entry_irq` then gives the qualifying interrupt with the lowest priority value. Ties go to the lowest interrupt number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_wait_req | input | 1 | Wait-for-interrupt sleep request |
| evt_wait_req | input | 1 | Wait-for-event sleep request |
| exit_sleep_req | input | 1 | Sleep-on-exit request |
| ext_event | input | 1 | External event input; sets the event flag |
| irq_pend | input | NUM_IRQ | Pending bit of each interrupt |
| irq_en | input | NUM_IRQ | Enable bit of each interrupt |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority value of each interrupt; interrupt i is in bits [i*PRIO_W +: PRIO_W] |
| exec_prio | input | PRIO_W+1 | Current execution priority |
| hold_mask | input | 1 | Global hold mask; defers handler entry but not wake-up |
| boost_mask | input | 1 | Fault mask; no interrupt qualifies while it is set |
| evt_on_new | input | 1 | When set, a new pending edge generates an event |
| sleeping | output | 1 | The core is asleep |
| wake_pulse | output | 1 | One-cycle wake pulse |
| entry_ok | output | 1 | Handler entry is permitted |
| entry_irq | output | $clog2(NUM_IRQ) | Number of the winning interrupt |

## Verification
In wait-for-event sleep, the event flag and the qualifying-interrupt path can both request a wake in the same cycle. The bench also sets up a new pending edge on a disabled interrupt in the same cycle that the new-pending-event control is turned on, and checks that exactly one wake pulse follows. Handler entry and the hold mask also meet in one cycle: the bench clears the mask while the controller sits in the deferred state, and expects the grant in that same cycle with the right interrupt number. A wait-for-event request that meets an already-set flag must consume the flag without sleeping, and the next request must then sleep.

// File: rtl/slpw_pkg.sv
package slpw_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_WFI,
        ST_SOE,
        ST_WFE,
        ST_WAKE,
        ST_DEFER
    } slp_state_e;

endpackage

// File: rtl/slpw_arbiter.sv
module slpw_arbiter #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 3,
    parameter int EXEC_W  = 4
) (
    input  logic [NUM_IRQ-1:0]        pend,
    input  logic [NUM_IRQ-1:0]        en,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input  logic [EXEC_W-1:0]         eff_exec,
    output logic                      any_qual,
    output logic [IDX_W-1:0]          win_idx
);

    logic [PRIO_W-1:0]  prio_a [NUM_IRQ];
    logic [NUM_IRQ-1:0] qual;

    // Each interrupt is judged on its own against the effective priority.
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_qual
        assign prio_a[g] = prio_flat[g*PRIO_W +: PRIO_W];
        assign qual[g]   = pend[g] & en[g] & ({1'b0, prio_a[g]} < eff_exec);
    end

    assign any_qual = |qual;

    // Scan upward; strict compare keeps the lower index on ties.
    always_comb begin
        logic              found;
        logic [PRIO_W-1:0] best;
        found   = 1'b0;
        best    = '1;
        win_idx = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (qual[i] && (!found || prio_a[i] < best)) begin
                found   = 1'b1;
                best    = prio_a[i];
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/slpw_event.sv
module slpw_event #(
    parameter int NUM_IRQ = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] pend,
    input  logic               evt_on_new,
    input  logic               ext_event,
    input  logic               consume,
    output logic               ev_flag,
    output logic               ev_set
);

    logic [NUM_IRQ-1:0] pend_q;
    logic [NUM_IRQ-1:0] rise;

    assign rise   = pend & ~pend_q;
    assign ev_set = ext_event | (evt_on_new & (|rise));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            ev_flag <= 1'b0;
        end else begin
            pend_q <= pend;
            if (consume) begin
                ev_flag <= 1'b0;
            end else if (ev_set) begin
                ev_flag <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/slpw_ctrl.sv
module slpw_ctrl #(
    parameter int NUM_IRQ = 8,
    parameter int PRIO_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        irq_wait_req,
    input  logic                        evt_wait_req,
    input  logic                        exit_sleep_req,
    input  logic                        ext_event,
    input  logic [NUM_IRQ-1:0]          irq_pend,
    input  logic [NUM_IRQ-1:0]          irq_en,
    input  logic [NUM_IRQ*PRIO_W-1:0]   irq_prio,
    input  logic [PRIO_W:0]             exec_prio,
    input  logic                        hold_mask,
    input  logic                        boost_mask,
    input  logic                        evt_on_new,
    output logic                        sleeping,
    output logic                        wake_pulse,
    output logic                        entry_ok,
    output logic [$clog2(NUM_IRQ)-1:0]  entry_irq
);

    import slpw_pkg::*;

    localparam int IDX_W  = $clog2(NUM_IRQ);
    localparam int EXEC_W = PRIO_W + 1;

    slp_state_e        state_q, state_d;
    logic [EXEC_W-1:0] eff_exec;
    logic              any_qual;
    logic [IDX_W-1:0]  win_idx;
    logic              ev_flag, ev_set, consume;

    // Fault mask lifts the effective level above every configurable value.
    assign eff_exec = boost_mask ? '0 : exec_prio;

    slpw_arbiter #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W),
        .EXEC_W  (EXEC_W)
    ) u_arb (
        .pend      (irq_pend),
        .en        (irq_en),
        .prio_flat (irq_prio),
        .eff_exec  (eff_exec),
        .any_qual  (any_qual),
        .win_idx   (win_idx)
    );

    slpw_event #(
        .NUM_IRQ (NUM_IRQ)
    ) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (irq_pend),
        .evt_on_new (evt_on_new),
        .ext_event  (ext_event),
        .consume    (consume),
        .ev_flag    (ev_flag),
        .ev_set     (ev_set)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        consume = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (irq_wait_req) begin
                    state_d = ST_WFI;
                end else if (exit_sleep_req) begin
                    state_d = ST_SOE;
                end else if (evt_wait_req) begin
                    if (ev_flag) begin
                        consume = 1'b1;
                    end else begin
                        state_d = ST_WFE;
                    end
                end
            end
            ST_WFI, ST_SOE: begin
                if (any_qual) begin
                    state_d = ST_WAKE;
                end
            end
            ST_WFE: begin
                if (any_qual || ev_flag || ev_set) begin
                    state_d = ST_WAKE;
                    consume = 1'b1;
                end
            end
            ST_WAKE: begin
                state_d = (any_qual && hold_mask) ? ST_DEFER : ST_RUN;
            end
            ST_DEFER: begin
                if (!hold_mask || !any_qual) begin
                    state_d = ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        sleeping   = 1'b0;
        wake_pulse = 1'b0;
        entry_ok   = 1'b0;
        entry_irq  = win_idx;
        unique case (state_q)
            ST_WFI, ST_SOE, ST_WFE: sleeping = 1'b1;
            ST_WAKE: begin
                sleeping   = 1'b1;
                wake_pulse = 1'b1;
            end
            ST_RUN, ST_DEFER: entry_ok = any_qual & ~hold_mask;
            default: ;
        endcase
    end

endmodule

module slpw_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic sleeping,
    input logic wake_pulse,
    input logic entry_ok,
    input logic hold_mask,
    input logic boost_mask
);

    // R4
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R4
    wake_then_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !sleeping);

    // R4
    wake_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> sleeping);

    // R5
    entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_ok |-> !hold_mask);

    // R6
    entry_boost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_ok |-> !boost_mask);

    // R12
    entry_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        entry_ok |-> !sleeping);

endmodule

bind slpw_ctrl slpw_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleeping   (sleeping),
    .wake_pulse (wake_pulse),
    .entry_ok   (entry_ok),
    .hold_mask  (hold_mask),
    .boost_mask (boost_mask)
);

// File: tb/slpw_ctrl_test.sv
module slpw_ctrl_test;

    localparam int N  = 8;
    localparam int PW = 3;
    localparam int IW = $clog2(N);

    typedef struct {
        string tag;
        bit    slp;
        bit    wk;
        bit    ent;
        int    irq;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            irq_wait_req = 0, evt_wait_req = 0, exit_sleep_req = 0, ext_event = 0;
    logic [N-1:0]    irq_pend = '0, irq_en = '0;
    logic [N*PW-1:0] irq_prio = '0;
    logic [PW:0]     exec_prio = 4'd8;
    logic            hold_mask = 0, boost_mask = 0, evt_on_new = 0;
    logic            sleeping, wake_pulse, entry_ok;
    logic [IW-1:0]   entry_irq;

    int   compared = 0;
    int   mismatched = 0;
    bit   done = 0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    slpw_ctrl #(.NUM_IRQ(N), .PRIO_W(PW)) uut (
        .clk(clk), .rst_n(rst_n),
        .irq_wait_req(irq_wait_req), .evt_wait_req(evt_wait_req),
        .exit_sleep_req(exit_sleep_req), .ext_event(ext_event),
        .irq_pend(irq_pend), .irq_en(irq_en), .irq_prio(irq_prio),
        .exec_prio(exec_prio), .hold_mask(hold_mask), .boost_mask(boost_mask),
        .evt_on_new(evt_on_new), .sleeping(sleeping), .wake_pulse(wake_pulse),
        .entry_ok(entry_ok), .entry_irq(entry_irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_now(string tag, bit slp, bit wk, bit ent, int irq);
        exp_t e;
        e.tag = tag; e.slp = slp; e.wk = wk; e.ent = ent; e.irq = irq;
        exp_q.push_back(e);
    endtask

    task automatic set_prio(int idx, int val);
        irq_prio[idx*PW +: PW] = PW'(val);
    endtask

    task automatic clear_irqs();
        irq_pend = '0; irq_en = '0; irq_prio = '0; exec_prio = 4'd8;
    endtask

    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            compared++;
            if (sleeping !== e.slp || wake_pulse !== e.wk || entry_ok !== e.ent ||
                (e.irq >= 0 && int'(entry_irq) != e.irq)) begin
                mismatched++;
                $display("FAIL %s: got slp=%0b wk=%0b ent=%0b irq=%0d, expected slp=%0b wk=%0b ent=%0b irq=%0d",
                         e.tag, sleeping, wake_pulse, entry_ok, entry_irq, e.slp, e.wk, e.ent, e.irq);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        expect_now("R1 reset outputs", 0, 0, 0, -1);

        // R2 / R3 / R4: wait-for-interrupt sleep, qualification and wake
        tick(); irq_wait_req = 1; expect_now("R2 still awake", 0, 0, 0, -1);
        tick(); irq_wait_req = 0; expect_now("R2 asleep", 1, 0, 0, -1);
        tick(); irq_pend[3] = 1; set_prio(3, 5); expect_now("R3 disabled", 1, 0, 0, -1);
        tick(); expect_now("R3 disabled held", 1, 0, 0, -1);
        tick(); irq_en[3] = 1; exec_prio = 4'd5; expect_now("R3 equal prio", 1, 0, 0, -1);
        tick(); expect_now("R3 equal prio held", 1, 0, 0, -1);
        tick(); exec_prio = 4'd6; expect_now("R3 qualifies", 1, 0, 0, -1);
        tick(); expect_now("R4 wake pulse", 1, 1, 0, -1);
        tick(); expect_now("R4 awake with entry", 0, 0, 1, 3);
        tick(); clear_irqs(); expect_now("R12 idle", 0, 0, 0, -1);

        // R12 arbitration
        tick(); irq_pend = 8'b0010_0110; irq_en = 8'b0010_0110;
        set_prio(1, 4); set_prio(2, 2); set_prio(5, 2);
        expect_now("R12 tie lowest index", 0, 0, 1, 2);
        tick(); set_prio(5, 1); expect_now("R12 lowest value", 0, 0, 1, 5);
        tick(); clear_irqs(); expect_now("R12 none", 0, 0, 0, -1);

        // R5 hold mask defers entry
        tick(); hold_mask = 1; irq_wait_req = 1; expect_now("R5 pre", 0, 0, 0, -1);
        tick(); irq_wait_req = 0; expect_now("R5 asleep", 1, 0, 0, -1);
        tick(); irq_pend[4] = 1; irq_en[4] = 1; set_prio(4, 1); expect_now("R5 arrive", 1, 0, 0, -1);
        tick(); expect_now("R5 wakes", 1, 1, 0, -1);
        tick(); expect_now("R5 deferred", 0, 0, 0, -1);
        tick(); expect_now("R5 still deferred", 0, 0, 0, -1);
        tick(); hold_mask = 0; expect_now("R5 released", 0, 0, 1, 4);
        tick(); expect_now("R5 entry held", 0, 0, 1, 4);
        tick(); clear_irqs(); expect_now("R5 idle", 0, 0, 0, -1);

        // R6 boost mask blocks qualification
        tick(); boost_mask = 1; irq_wait_req = 1; expect_now("R6 pre", 0, 0, 0, -1);
        tick(); irq_wait_req = 0; irq_pend[0] = 1; irq_en[0] = 1; set_prio(0, 0);
        expect_now("R6 asleep", 1, 0, 0, -1);
        tick(); expect_now("R6 no wake", 1, 0, 0, -1);
        tick(); expect_now("R6 no wake again", 1, 0, 0, -1);
        tick(); boost_mask = 0; expect_now("R6 lifted", 1, 0, 0, -1);
        tick(); expect_now("R6 wake", 1, 1, 0, -1);
        tick(); expect_now("R6 entry", 0, 0, 1, 0);
        tick(); boost_mask = 1; expect_now("R6 entry blocked", 0, 0, 0, -1);
        tick(); boost_mask = 0; clear_irqs(); expect_now("R6 idle", 0, 0, 0, -1);

        // R7 sleep-on-exit
        tick(); exit_sleep_req = 1; expect_now("R7 pre", 0, 0, 0, -1);
        tick(); exit_sleep_req = 0; irq_pend[6] = 1; irq_en[6] = 1; set_prio(6, 7);
        exec_prio = 4'd7; expect_now("R7 asleep", 1, 0, 0, -1);
        tick(); expect_now("R7 low prio no wake", 1, 0, 0, -1);
        tick(); exec_prio = 4'd8; expect_now("R7 qualifies", 1, 0, 0, -1);
        tick(); expect_now("R7 wake", 1, 1, 0, -1);
        tick(); expect_now("R7 entry", 0, 0, 1, 6);
        tick(); clear_irqs(); expect_now("R7 idle", 0, 0, 0, -1);

        // R8 wait-for-event wakes on qualifying interrupt
        tick(); evt_wait_req = 1; expect_now("R8 pre", 0, 0, 0, -1);
        tick(); evt_wait_req = 0; expect_now("R8 asleep", 1, 0, 0, -1);
        tick(); irq_pend[2] = 1; irq_en[2] = 1; set_prio(2, 3); expect_now("R8 arrive", 1, 0, 0, -1);
        tick(); expect_now("R8 wake", 1, 1, 0, -1);
        tick(); expect_now("R8 entry", 0, 0, 1, 2);
        tick(); clear_irqs(); expect_now("R8 idle", 0, 0, 0, -1);

        // R9 / R10 new-pending events
        tick(); irq_pend[7] = 1; expect_now("R10 pending before sleep", 0, 0, 0, -1);
        tick(); evt_on_new = 1; evt_wait_req = 1; expect_now("R10 pre", 0, 0, 0, -1);
        tick(); evt_wait_req = 0; evt_on_new = 0; expect_now("R10 asleep", 1, 0, 0, -1);
        tick(); expect_now("R10 old pending no event", 1, 0, 0, -1);
        tick(); irq_pend[6] = 1; expect_now("R9 edge without control", 1, 0, 0, -1);
        tick(); expect_now("R9 stays asleep", 1, 0, 0, -1);
        tick(); evt_on_new = 1; irq_pend[5] = 1; expect_now("R9 edge with control", 1, 0, 0, -1);
        tick(); expect_now("R9 wake", 1, 1, 0, -1);
        tick(); expect_now("R9 awake no entry", 0, 0, 0, -1);
        tick(); clear_irqs(); evt_on_new = 0; expect_now("R9 idle", 0, 0, 0, -1);

        // R11 event flag
        tick(); ext_event = 1; expect_now("R11 set", 0, 0, 0, -1);
        tick(); ext_event = 0; evt_wait_req = 1; expect_now("R11 request", 0, 0, 0, -1);
        tick(); evt_wait_req = 0; expect_now("R11 consumed no sleep", 0, 0, 0, -1);
        tick(); evt_wait_req = 1; expect_now("R11 second request", 0, 0, 0, -1);
        tick(); evt_wait_req = 0; expect_now("R11 sleeps", 1, 0, 0, -1);
        tick(); ext_event = 1; expect_now("R11 event in sleep", 1, 0, 0, -1);
        tick(); ext_event = 0; expect_now("R11 wake", 1, 1, 0, -1);
        tick(); expect_now("R11 awake", 0, 0, 0, -1);

        // R1 reset clears the event flag
        tick(); ext_event = 1;
        tick(); ext_event = 0; rst_n = 0;
        tick();
        tick(); rst_n = 1; evt_wait_req = 1; expect_now("R1 after reset", 0, 0, 0, -1);
        tick(); evt_wait_req = 0; expect_now("R1 flag cleared, sleeps", 1, 0, 0, -1);

        tick();
        @(negedge clk); #1;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule